// File: doc/BRIEF.md
# Bit-Sliced ALU with Signed Compare

A 32-bit arithmetic logic unit assembled from identical one-bit slices. The carry chain starts at bit 0 and ends at bit 31. Each slice can invert either input. It offers an AND path, an OR path and a full adder. From these the unit builds the four bitwise functions, addition and subtraction.

A compare stage watches the most significant slice during a subtraction. It turns the sign, the overflow and the zero-detect of that difference into one of six signed conditions. The condition is written as a 0 or 1 result.

Outputs are registered. A result appears on the rising edge after the operands are presented. While the active-low reset is 0, the result and all flags stay at 0.

Top module: `bsalu`

## Requirements
- R1: Operation select 0000 gives a AND b, 0001 gives a OR b, 1100 gives NOR(a, b) and 1101 gives NAND(a, b); carry and overflow flags are 0 for these.
- R2: Operation select 0010 gives a + b modulo 2^32; the carry flag is the carry out of bit 31 and the overflow flag is 1 when both operands have the same sign and the sum's sign differs.
- R3: Operation select 0110 gives a - b modulo 2^32, formed as a + ~b + 1; the carry flag is the carry out of bit 31 of that sum (1 means no borrow) and the overflow flag is 1 when the operands' signs differ and the result's sign differs from a.
- R4: With operation select 0111, the compare select picks a signed ordering test: 000 a<b, 001 a>b, 010 a<=b, 011 a>=b.
- R5: With operation select 0111, compare select 110 tests a==b and 100 tests a!=b; the codes 101 and 111 give a false outcome.
- R6: For every operation select 0111 result, bit 0 holds the outcome (1 true) and bits 31 to 1 are 0, and the carry and overflow flags are 0.
- R7: The zero flag is 1 exactly when the registered 32-bit result is all zeros (while reset is 1).
- R8: While reset is 0, the result, zero, carry and overflow outputs are 0 on every clock edge; with reset at 1, each output reflects the inputs sampled on the previous rising edge.
- R9: Any operation select not listed in R1 to R6 gives a result of 0 with carry and overflow 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset; outputs forced to 0 while low |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| op | input | 4 | Operation select |
| cmp | input | 3 | Compare condition select, used with op 0111 |
| result | output | 32 | Registered result |
| zero | output | 1 | Result-is-zero flag |
| cout | output | 1 | Carry out of bit 31 for add and subtract |
| ovf | output | 1 | Signed overflow for add and subtract |

## Verification
Random operand pairs over all operation and compare codes cover the general case. Directed pairs target the edges of the signed range. The most negative value minus one, and the most positive value plus one, separate a correct overflow from a plain carry test. Equal operands, and pairs that differ only in sign, show whether the less-than decision includes the overflow correction and whether the equality tests depend on the zero-detect. A reset pulse in the middle of a run, and the unused select codes, confirm that the outputs collapse to 0 rather than hold stale values.

// File: rtl/bsalu.sv
module bsalu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  input  logic [2:0]   cmp,
  output logic [W-1:0] result,
  output logic         zero,
  output logic         cout,
  output logic         ovf
);
  localparam logic [3:0] OP_AND  = 4'b0000;
  localparam logic [3:0] OP_OR   = 4'b0001;
  localparam logic [3:0] OP_ADD  = 4'b0010;
  localparam logic [3:0] OP_SUB  = 4'b0110;
  localparam logic [3:0] OP_SET  = 4'b0111;
  localparam logic [3:0] OP_NOR  = 4'b1100;
  localparam logic [3:0] OP_NAND = 4'b1101;

  wire is_and  = (op == OP_AND);
  wire is_or   = (op == OP_OR);
  wire is_add  = (op == OP_ADD);
  wire is_sub  = (op == OP_SUB);
  wire is_set  = (op == OP_SET);
  wire is_nor  = (op == OP_NOR);
  wire is_nand = (op == OP_NAND);
  wire is_arith = is_add | is_sub;

  wire inv_a = is_nor;
  wire inv_b = is_nor | is_sub | is_set;

  logic [W:0]   c;
  logic [W-1:0] s, g, p, bit_o;
  assign c[0] = is_sub | is_set;

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic ai, bi;
    assign ai     = a[i] ^ inv_a;
    assign bi     = b[i] ^ inv_b;
    assign g[i]   = ai & bi;
    assign p[i]   = ai | bi;
    assign s[i]   = ai ^ bi ^ c[i];
    assign c[i+1] = g[i] | (c[i] & (ai ^ bi));
    assign bit_o[i] = ((is_and | is_nor) & g[i])
                    | (is_nand & ~g[i])
                    | (is_or & p[i])
                    | (is_arith & s[i]);
  end

  wire ovf_raw = c[W] ^ c[W-1];
  wire less    = s[W-1] ^ ovf_raw;
  wire equal   = ~|s;

  logic cond;
  always_comb begin
    case (cmp)
      3'b000:  cond = less;
      3'b001:  cond = ~less & ~equal;
      3'b010:  cond = less | equal;
      3'b011:  cond = ~less;
      3'b110:  cond = equal;
      3'b100:  cond = ~equal;
      default: cond = 1'b0;
    endcase
  end

  wire [W-1:0] r_next = {bit_o[W-1:1], bit_o[0] | (is_set & cond)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      zero   <= 1'b0;
      cout   <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      result <= r_next;
      zero   <= ~|r_next;
      cout   <= is_arith & c[W];
      ovf    <= is_arith & ovf_raw;
    end
  end

  p_add_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADD) |=> (result == $past(a) + $past(b)));

  p_sub_diff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SUB) |=> (result == $past(a) - $past(b)));

  p_set_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SET) |=> (result[W-1:1] == '0 && !cout && !ovf));

  p_zero_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zero |-> (result == '0));

  p_no_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(op == OP_ADD || op == OP_SUB) |=> (!cout && !ovf));
endmodule

// File: tb/tb_bsalu.sv
module tb_bsalu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [3:0]  op = '0;
  logic [2:0]  cmp = '0;
  logic [31:0] result;
  logic        zero, cout, ovf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bsalu dut (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .op(op), .cmp(cmp),
             .result(result), .zero(zero), .cout(cout), .ovf(ovf));

  function automatic logic [34:0] model(logic [3:0] o, logic [2:0] k,
                                        logic [31:0] x, logic [31:0] y);
    logic [32:0] w;
    logic [31:0] r;
    logic c, v, t;
    r = '0; c = 0; v = 0; t = 0;
    case (o)
      4'b0000: r = x & y;
      4'b0001: r = x | y;
      4'b1100: r = ~(x | y);
      4'b1101: r = ~(x & y);
      4'b0010: begin
        w = {1'b0, x} + {1'b0, y};
        r = w[31:0]; c = w[32];
        v = (x[31] == y[31]) && (r[31] != x[31]);
      end
      4'b0110: begin
        w = {1'b0, x} + {1'b0, ~y} + 33'd1;
        r = w[31:0]; c = w[32];
        v = (x[31] != y[31]) && (r[31] != x[31]);
      end
      4'b0111: begin
        case (k)
          3'b000: t = $signed(x) <  $signed(y);
          3'b001: t = $signed(x) >  $signed(y);
          3'b010: t = $signed(x) <= $signed(y);
          3'b011: t = $signed(x) >= $signed(y);
          3'b110: t = x == y;
          3'b100: t = x != y;
          default: t = 0;
        endcase
        r = {31'd0, t};
      end
      default: r = '0;
    endcase
    return {c, v, (r == 0), r};
  endfunction

  function automatic string tag(logic [3:0] o, logic [2:0] k);
    case (o)
      4'b0000, 4'b0001, 4'b1100, 4'b1101: return "R1";
      4'b0010: return "R2";
      4'b0110: return "R3";
      4'b0111: return (k == 3'b110 || k[2:1] == 2'b10 || k == 3'b111) ? "R5/R6" : "R4/R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string rq, logic [34:0] got, logic [34:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got c=%b v=%b z=%b r=%h expected c=%b v=%b z=%b r=%h",
               rq, got[34], got[33], got[32], got[31:0],
               exp[34], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic run(logic [3:0] o, logic [2:0] k, logic [31:0] x, logic [31:0] y);
    @(negedge clk);
    op = o; cmp = k; a = x; b = y;
    @(negedge clk);
    check({tag(o, k), " R7"}, {cout, ovf, zero, result}, model(o, k, x, y));
  endtask

  localparam logic [3:0] OPS [7] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110,
                                     4'b0111, 4'b1100, 4'b1101};
  localparam logic [2:0] CMPS [6] = '{3'b000, 3'b001, 3'b010, 3'b011,
                                      3'b110, 3'b100};

  initial begin
    int unsigned seed;
    logic [31:0] corner [6];
    seed = 32'd2024;
    void'($urandom(seed));
    corner = '{32'h8000_0000, 32'h7fff_ffff, 32'h0000_0000,
               32'hffff_ffff, 32'h0000_0001, 32'h1234_5678};

    op = 4'b0010; a = 32'h7fff_ffff; b = 32'd1;
    repeat (3) @(negedge clk);
    check("R8 reset", {cout, ovf, zero, result}, 35'd0);
    rst_n = 1'b1;

    run(4'b0010, 0, 32'h7fff_ffff, 32'd1);
    run(4'b0010, 0, 32'hffff_ffff, 32'd1);
    run(4'b0010, 0, 32'h8000_0000, 32'h8000_0000);
    run(4'b0110, 0, 32'h8000_0000, 32'd1);
    run(4'b0110, 0, 32'h7fff_ffff, 32'hffff_ffff);
    run(4'b0110, 0, 32'd5, 32'd5);
    run(4'b0110, 0, 32'd0, 32'd1);
    run(4'b1100, 0, 32'h0f0f_0000, 32'h00ff_0000);
    run(4'b1101, 0, 32'hffff_ffff, 32'hffff_ffff);
    run(4'b0000, 0, 32'haaaa_aaaa, 32'h5555_5555);

    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int k = 0; k < 6; k++)
          run(4'b0111, CMPS[k], corner[i], corner[j]);

    run(4'b0111, 3'b101, 32'd3, 32'd4);
    run(4'b0111, 3'b111, 32'd3, 32'd3);
    for (int u = 0; u < 16; u++)
      if (u[3:0] inside {4'b0011, 4'b0100, 4'b0101, 4'b1000, 4'b1111})
        run(u[3:0], 3'b000, 32'hdead_beef, 32'h1234_5678);

    for (int n = 0; n < 400; n++)
      run(OPS[$urandom_range(0, 6)], CMPS[$urandom_range(0, 5)],
          $urandom(), (n % 5 == 0) ? 32'h8000_0000 ^ $urandom_range(0, 1) : $urandom());

    @(negedge clk);
    op = 4'b0001; a = 32'hffff_ffff; b = 0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 mid reset", {cout, ovf, zero, result}, 35'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 release", {cout, ovf, zero, result}, model(4'b0001, 0, 32'hffff_ffff, 0));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule